// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This block sits between a memory controller's four active-low chip-enable lines and four memory devices. While supply power is good it passes the enables straight through, after steering them into one of three bank arrangements chosen by a mode input and a two-bit address. A digital power-fail flag from an external supply comparator closes the gate. Any access still running at that moment is allowed to finish, up to a bounded grace time. Every output is then held inactive until a recovery interval has passed after power returns.

The power-fail flag is asynchronous and is brought into the clock domain through a two-flop synchroniser. The bank arrangement is captured once, on the first cycle in which the synchronised flag is seen low after being high. All timings are parameters counted in clock cycles.

Top module: `pf_ce_guard`

## Requirements
- R1: With mode code 0 latched and the gate open, `ce_out_n[k]` equals `ce_in_n[k]` for each k, combinationally.
- R2: With mode code 1 latched and the gate open, outputs 0 and 1 form a bank driven by `ce_in_n[0]` and outputs 2 and 3 form a bank driven by `ce_in_n[1]`. `bank_addr[0]`=0 selects the even output of each pair and 1 selects the odd one. The unselected output is high, and `ce_in_n[3:2]` are ignored.
- R3: With mode code 2 or 3 latched and the gate open, `ce_in_n[0]` reaches only output number `bank_addr` (0 to 3). All other outputs are high, and `ce_in_n[3:1]` are ignored.
- R4: `mode_sel` is captured only at the rising clock edge that follows the first edge at which the synchronised flag reads low after reading high. Changes at any other time have no effect on the decoding.
- R5: A `pwr_fail` level present at rising edge n reaches the channels at edge n+2. Any channel whose decoded enable is high at that edge is forced high from then on.
- R6: A channel whose decoded enable is low at that edge keeps following it for at most GRACE_CYC further edges. If the enable is still low, the channel is forced high at the GRACE_CYC-th edge. Each channel times its own window.
- R7: After a held channel's decoded enable goes high, the channel output stays high: the enable going low again does not reopen it.
- R8: If `pwr_fail` is low at edge n, a forced-high channel reopens at edge n+1+RECOV_CYC. The flag returning high during that wait restarts the wait.
- R9: While `rst_n` is low, all outputs are high. The block leaves reset as if power had just failed, so the gate is closed and the mode code is 0 until the first power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Asynchronous power-fail flag, high while supply is out of tolerance |
| mode_sel | input | 2 | Bank arrangement code, captured at power-up |
| bank_addr | input | 2 | Address bits used for bank steering |
| ce_in_n | input | 4 | Active-low chip enables from the controller |
| ce_out_n | output | 4 | Active-low chip enables to the memory devices |

## Verification
The assertions take for granted the following input conditions:
- `pwr_fail` is a level that may change on any cycle.
- The enable and address inputs settle between rising edges.
- `mode_sel` may change at any time.

The bench drives all inputs on the falling edge and holds them across the rising edge. The flag is toggled both in long outages and in one-cycle pulses, and sometimes during the recovery wait. During outages the enables and the address are changed randomly, so that held channels both finish early and run into the grace limit.

// File: rtl/pf_ce_guard.sv
module pf_ce_guard #(
  parameter int GRACE_CYC = 375,
  parameter int RECOV_CYC = 375
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_fail,
  input  logic [1:0] mode_sel,
  input  logic [1:0] bank_addr,
  input  logic [3:0] ce_in_n,
  output logic [3:0] ce_out_n
);
  localparam int NCH = 4;
  localparam int GW  = $clog2(GRACE_CYC + 1);
  localparam int RW  = $clog2(RECOV_CYC + 1);
  localparam int LW  = $clog2(GRACE_CYC + 3);

  typedef enum logic [1:0] {PASS, HOLD, SHUT} ch_st_t;

  logic          sync1, pf_s, pf_d;
  logic [RW-1:0] rec_cnt;
  logic [1:0]    mode_l;

  wire pwr_up = pf_d & ~pf_s;
  wire reopen = ~pf_s & (rec_cnt <= RW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b1;
      pf_s  <= 1'b1;
      pf_d  <= 1'b1;
    end else begin
      sync1 <= pwr_fail;
      pf_s  <= sync1;
      pf_d  <= pf_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              rec_cnt <= RW'(RECOV_CYC);
    else if (pf_s)           rec_cnt <= RW'(RECOV_CYC);
    else if (rec_cnt != '0)  rec_cnt <= rec_cnt - RW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mode_l <= 2'd0;
    else if (pwr_up) mode_l <= mode_sel;

  // checker-side counter: cycles of good power, saturating at the recovery length
  logic [RW-1:0] good_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        good_run <= '0;
    else if (pf_s)                     good_run <= '0;
    else if (good_run != RW'(RECOV_CYC)) good_run <= good_run + RW'(1);

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> ##2 pf_s);                                        // R5
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> $stable(mode_l));                                  // R4
  AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_l == 2'd1) |-> ($onehot0(~ce_out_n[1:0]) && $onehot0(~ce_out_n[3:2]))); // R2
  AST_QUAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_l[1] |-> $onehot0(~ce_out_n));                            // R3

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] IDX = 2'(i);
    localparam int         PAIR_IN = i / 2;

    ch_st_t        st;
    logic [GW-1:0] gcnt;
    logic          dec_n;

    always_comb
      case (mode_l)
        2'd0:    dec_n = ce_in_n[i];
        2'd1:    dec_n = ce_in_n[PAIR_IN] | (bank_addr[0] != IDX[0]);
        default: dec_n = ce_in_n[0] | (bank_addr != IDX);
      endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st   <= SHUT;
        gcnt <= '0;
      end else
        case (st)
          PASS: if (pf_s) begin
                  st   <= dec_n ? SHUT : HOLD;
                  gcnt <= GW'(GRACE_CYC);
                end
          HOLD: if (dec_n || gcnt == GW'(1)) st <= SHUT;
                else gcnt <= gcnt - GW'(1);
          default: if (reopen) st <= PASS;
        endcase

    assign ce_out_n[i] = (st == SHUT) | dec_n;

    logic [LW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) low_run <= '0;
      else if (ce_out_n[i] || !(pf_s || good_run < RW'(RECOV_CYC))) low_run <= '0;
      else if (low_run != LW'(GRACE_CYC + 2)) low_run <= low_run + LW'(1);

    AST_GRACE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= LW'(GRACE_CYC + 1));                              // R6
    AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_s && $past(pf_s) && $past(ce_out_n[i])) |-> ce_out_n[i]); // R7
    AST_RECOV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (good_run < RW'(RECOV_CYC) && $past(ce_out_n[i])) |-> ce_out_n[i]); // R8
  end
endmodule

// File: tb/pf_ce_guard_bench.sv
module pf_ce_guard_bench;
  localparam int G = 5;
  localparam int R = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] bank_addr = 2'd0;
  logic [3:0] ce_in_n = 4'hF;
  logic [3:0] ce_out_n;

  always #2 clk = ~clk;

  pf_ce_guard #(.GRACE_CYC(G), .RECOV_CYC(R)) u_pf_ce_guard (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .mode_sel(mode_sel),
    .bank_addr(bank_addr), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n));

  int total = 0, fails = 0;
  bit done = 0;

  // expected-behaviour model: flag age, recovery wait, per-channel phase
  logic       mh1 = 1, mh2 = 1, mh3 = 1;
  int         mrc = R;
  logic [1:0] mmode = 0;
  int         mph [4] = '{2, 2, 2, 2};   // 0 passing, 1 held, 2 forced high
  int         mgl [4] = '{0, 0, 0, 0};

  function automatic logic mdec(int i, logic [1:0] md, logic [3:0] cin, logic [1:0] a);
    if (md == 2'd0) return cin[i];
    if (md == 2'd1) return cin[i/2] | (a[0] != i[0]);
    return cin[0] | (a != i[1:0]);
  endfunction

  function automatic logic [3:0] mexp();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (mph[i] == 2) ? 1'b1 : mdec(i, mmode, ce_in_n, bank_addr);
    return e;
  endfunction

  function automatic string mtag();
    if (!rst_n) return "R9";
    for (int i = 0; i < 4; i++) if (mph[i] == 1) return "R6";
    if (mph[0] == 0 && mph[1] == 0 && mph[2] == 0 && mph[3] == 0)
      return (mmode == 0) ? "R1" : (mmode == 1) ? "R2" : "R3";
    return mh2 ? "R5" : "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh1 <= 1; mh2 <= 1; mh3 <= 1; mrc <= R; mmode <= 0;
      for (int i = 0; i < 4; i++) begin mph[i] <= 2; mgl[i] <= 0; end
    end else begin
      mh1 <= pwr_fail; mh2 <= mh1; mh3 <= mh2;
      if (mh2) mrc <= R; else if (mrc != 0) mrc <= mrc - 1;
      if (mh3 && !mh2) mmode <= mode_sel;
      for (int i = 0; i < 4; i++) begin
        logic d;
        d = mdec(i, mmode, ce_in_n, bank_addr);
        if (mph[i] == 0) begin
          if (mh2) begin mph[i] <= d ? 2 : 1; mgl[i] <= G; end
        end else if (mph[i] == 1) begin
          if (d || mgl[i] == 1) mph[i] <= 2; else mgl[i] <= mgl[i] - 1;
        end else if (!mh2 && mrc <= 1) mph[i] <= 0;
      end
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ce_out_n=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(mtag(), ce_out_n, mexp());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) tick();
    check("R9", ce_out_n, 4'hF);
    rst_n = 1'b1;
    tick(); tick();
    mode_sel = 2'd0; pwr_fail = 1'b0;
    repeat (R + 4) tick();
    ce_in_n = 4'b0110; tick();
    check("R1", ce_out_n, 4'b0110);
    mode_sel = 2'd2; ce_in_n = 4'b1110; bank_addr = 2'd2; repeat (3) tick();
    check("R4", ce_out_n, 4'b1110);
    // outage with channels 0 and 2 busy
    ce_in_n = 4'b1010; pwr_fail = 1'b1;
    repeat (3) tick();
    check("R5", ce_out_n, 4'b1010);
    ce_in_n = 4'b1011; tick();
    ce_in_n = 4'b1010; tick(); tick();
    check("R7", {ce_out_n[3:1], ce_out_n[0]}, 4'b1011);
    repeat (G + 3) tick();
    check("R6", ce_out_n, 4'hF);
    pwr_fail = 1'b0; ce_in_n = 4'b1110; bank_addr = 2'd2;
    repeat (R + 3) tick();
    check("R3", ce_out_n, 4'b1011);
    // restart of the recovery wait
    pwr_fail = 1'b1; tick(); tick(); tick(); pwr_fail = 1'b0;
    repeat (R - 3) tick(); pwr_fail = 1'b1; tick(); pwr_fail = 1'b0;
    repeat (R) tick();
    check("R8", ce_out_n, 4'hF);
    repeat (6) tick();
    // pair mode
    pwr_fail = 1'b1; mode_sel = 2'd1; repeat (4) tick();
    pwr_fail = 1'b0; repeat (R + 4) tick();
    ce_in_n = 4'b0000; bank_addr = 2'd1; tick();
    check("R2", ce_out_n, 4'b0101);
    // random episodes
    for (int ep = 0; ep < 60; ep++) begin
      int up_len, down_len;
      up_len = 10 + int'($urandom_range(40));
      down_len = 1 + int'($urandom_range(G + 6));
      for (int c = 0; c < up_len; c++) begin
        ce_in_n = 4'($urandom); bank_addr = 2'($urandom);
        if ($urandom_range(7) == 0) mode_sel = 2'($urandom);
        tick();
      end
      pwr_fail = 1'b1;
      for (int c = 0; c < down_len; c++) begin
        for (int b = 0; b < 4; b++) if ($urandom_range(3) == 0) ce_in_n[b] = ~ce_in_n[b];
        if ($urandom_range(5) == 0) bank_addr = 2'($urandom);
        mode_sel = 2'($urandom);
        tick();
      end
      pwr_fail = 1'b0;
      for (int c = 0; c < R + 4; c++) begin
        if ($urandom_range(15) == 0) pwr_fail = 1'b1; else pwr_fail = 1'b0;
        if ($urandom_range(2) == 0) ce_in_n = 4'($urandom);
        tick();
      end
      pwr_fail = 1'b0;
      repeat (R + 4) tick();
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule